// File: doc/BRIEF.md
# Gap-Aligned Checked Frame Receiver

This block sits behind a byte-level serial receiver and turns a stream of received bytes into fixed-length checked frames. The line carries no header and no delimiter; frame alignment comes only from silence. A gap counter, clocked by an external periodic tick, is reloaded by every accepted byte. When a byte arrives after that counter has already run down to zero, the byte opens a new frame at position zero. Any line error reported by the receiver (overrun, framing or parity) throws away the partial frame.

When the last byte of a frame arrives, it is compared with a check value. The check value is a fixed seed XORed with every payload byte. A match raises a one-cycle good pulse and updates a payload register. A mismatch raises a one-cycle bad pulse and leaves the payload register untouched. In both cases the assembly position returns to zero. The same byte also loads a completion timer, which counts down on ticks and is exposed so that nearby logic can tell how recently a frame ended.

The byte input is a valid/ready stream. The block never applies back-pressure: `in_ready` is high in every cycle, including reset, and a byte is taken in any cycle where `in_valid` is high and no error flag is raised. The producer therefore never needs to hold a byte. The tick and error inputs are plain one-cycle strobes.

Top module: `gap_framed_rx`

## Requirements
- R1: An accepted byte (`in_valid` high and all three error flags low) is stored at the current frame position, and the position then advances by one. Bytes fill the frame in arrival order.
- R2: If the gap counter is already zero when a byte is accepted, that byte is stored as byte 0 of a new frame, whatever the previous position was.
- R3: Every accepted byte reloads the gap counter to GAP_TICKS (default 5). In a cycle with `tick` high and no accepted byte, the counter decrements by one and holds at zero. Bytes spaced by GAP_TICKS-1 ticks stay in one frame; a spacing of GAP_TICKS ticks or more starts a new frame.
- R4: The byte that completes a frame (the FRAME_LEN-th byte, default 6) loads `done_timer` with DONE_TICKS (default 20). Otherwise `done_timer` decrements on each `tick` and holds at zero. `done_timer` already shows DONE_TICKS in the cycle of the good or bad pulse.
- R5: A frame is good only when its last byte equals SEED (default 0x5A) XOR byte 0 through byte FRAME_LEN-2. The cycle after the completing byte is accepted, exactly one of `frame_good` or `frame_bad` is high for one cycle; the two are never high together.
- R6: After a frame completes, good or bad, the position is zero. The next accepted byte, even with no gap, is byte 0 of the next frame.
- R7: Any of `err_overrun`, `err_framing` or `err_parity` resets the position to zero. A byte presented in the same cycle as an error is dropped, and no pulse follows an error cycle.
- R8: `payload` holds byte k of the last good frame at bits [8k+7:8k] (byte 0 in the low bits). It changes only in the cycle in which `frame_good` is high. A bad frame leaves it unchanged.
- R9: `in_ready` is always 1. After reset, `frame_good`, `frame_bad`, `payload` and `done_timer` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received byte present |
| in_ready | output | 1 | Byte accepted; always 1 |
| in_data | input | DATA_W (8) | Received byte |
| err_overrun | input | 1 | Receiver overrun strobe |
| err_framing | input | 1 | Receiver framing error strobe |
| err_parity | input | 1 | Receiver parity error strobe |
| tick | input | 1 | Periodic timer tick, one cycle wide |
| frame_good | output | 1 | One-cycle pulse: frame passed its check |
| frame_bad | output | 1 | One-cycle pulse: frame failed its check |
| payload | output | (FRAME_LEN-1)*DATA_W (40) | Payload bytes of the last good frame |
| done_timer | output | TMR_W (8) | Completion timer, counts down after each frame |

## Verification
The bench uses the default parameters: eight-bit bytes, six-byte frames, seed 0x5A, a gap of 5 ticks and a completion time of 20 ticks. The bench drives the tick input directly, one strobe at a time. This puts the exact gap boundary in reach: spacing bytes 4 ticks apart keeps them in one frame, while 5 ticks restarts alignment. The completion timer can be followed through its load, its steady countdown and its hold at zero within a few dozen cycles. Error strobes are placed both alone and in the same cycle as a byte. A misaligned or miscounted frame then shows up as a wrong pulse against the behavioural queue model.

// File: rtl/gfr_pkg.sv
package gfr_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_GOOD = 2'd1,
    VERDICT_BAD  = 2'd2
  } verdict_e;

endpackage

// File: rtl/sat_down_timer.sv
module sat_down_timer #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned RELOAD = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);
  localparam logic [CNT_W-1:0] ONE_V    = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= RELOAD_V;
    end else if (tick && count != '0) begin
      count <= count - ONE_V;
    end
  end

  // R3 / R4: load wins over tick
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == RELOAD_V);

  // R3 / R4: saturation at zero
  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && count == '0) |=> count == '0);

  // R3 / R4: one step per tick
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && count != '0) |=> count == $past(count) - ONE_V);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(count));

endmodule

// File: rtl/seeded_xor_check.sv
module seeded_xor_check #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N      = 5,
  parameter int unsigned SEED   = 8'h5A
) (
  input  logic [N*DATA_W-1:0] bytes_in,
  input  logic [DATA_W-1:0]   check_byte,
  output logic                match
);

  logic [DATA_W-1:0] acc [N+1];

  assign acc[0] = DATA_W'(SEED);

  for (genvar k = 0; k < N; k++) begin : g_fold
    assign acc[k+1] = acc[k] ^ bytes_in[k*DATA_W +: DATA_W];
  end

  assign match = (acc[N] == check_byte);

endmodule

// File: rtl/frame_assembler.sv
module frame_assembler
  import gfr_pkg::*;
#(
  parameter int unsigned DATA_W    = BYTE_W,
  parameter int unsigned FRAME_LEN = 6,
  parameter int unsigned SEED      = 8'h5A,
  localparam int unsigned PAY_N    = FRAME_LEN - 1,
  localparam int unsigned PAY_W    = PAY_N * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_acc,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              err_any,
  input  logic              gap_zero,
  output logic              frame_done,
  output logic              frame_good,
  output logic              frame_bad,
  output logic [PAY_W-1:0]  payload
);

  localparam int unsigned IDX_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] eff_idx;
  logic [PAY_W-1:0] cap_flat;
  logic             last_byte;
  logic             chk_ok;
  verdict_e         verdict_d, verdict_q;

  // a lapsed gap counter forces the incoming byte to position zero
  assign eff_idx   = gap_zero ? '0 : idx;
  assign last_byte = byte_acc && (eff_idx == LAST_IDX);
  assign frame_done = last_byte;

  for (genvar k = 0; k < PAY_N; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_flat[k*DATA_W +: DATA_W] <= '0;
      end else if (byte_acc && eff_idx == IDX_W'(k)) begin
        cap_flat[k*DATA_W +: DATA_W] <= byte_data;
      end
    end
  end

  seeded_xor_check #(
    .DATA_W (DATA_W),
    .N      (PAY_N),
    .SEED   (SEED)
  ) u_check (
    .bytes_in   (cap_flat),
    .check_byte (byte_data),
    .match      (chk_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (err_any) begin
      idx <= '0;
    end else if (byte_acc) begin
      idx <= last_byte ? '0 : eff_idx + ONE_IDX;
    end
  end

  always_comb begin
    verdict_d = VERDICT_NONE;
    if (last_byte) verdict_d = chk_ok ? VERDICT_GOOD : VERDICT_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_q <= VERDICT_NONE;
      payload   <= '0;
    end else begin
      verdict_q <= verdict_d;
      if (last_byte && chk_ok) payload <= cap_flat;
    end
  end

  assign frame_good = (verdict_q == VERDICT_GOOD);
  assign frame_bad  = (verdict_q == VERDICT_BAD);

  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);

  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && !gap_zero && idx != LAST_IDX) |=> idx == $past(idx) + ONE_IDX);

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && gap_zero && FRAME_LEN > 1) |=> idx == ONE_IDX);

  p_one_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_good && frame_bad));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> idx == '0);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> (idx == '0 && !frame_good && !frame_bad));

  p_pay_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_good |-> $stable(payload));

endmodule

// File: rtl/gap_framed_rx.sv
module gap_framed_rx
  import gfr_pkg::*;
#(
  parameter int unsigned DATA_W     = BYTE_W,
  parameter int unsigned FRAME_LEN  = 6,
  parameter int unsigned SEED       = 8'h5A,
  parameter int unsigned GAP_TICKS  = 5,
  parameter int unsigned DONE_TICKS = 20,
  parameter int unsigned TMR_W      = 8,
  localparam int unsigned PAY_W     = (FRAME_LEN - 1) * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              err_overrun,
  input  logic              err_framing,
  input  logic              err_parity,
  input  logic              tick,
  output logic              frame_good,
  output logic              frame_bad,
  output logic [PAY_W-1:0]  payload,
  output logic [TMR_W-1:0]  done_timer
);

  localparam logic [TMR_W-1:0] DONE_V = TMR_W'(DONE_TICKS);

  logic             err_any;
  logic             byte_acc;
  logic             frame_done;
  logic [TMR_W-1:0] gap_cnt;
  logic             gap_zero;

  assign in_ready = 1'b1;
  assign err_any  = err_overrun | err_framing | err_parity;
  // error wins over a byte in the same cycle
  assign byte_acc = in_valid && in_ready && !err_any;
  assign gap_zero = (gap_cnt == '0);

  sat_down_timer #(
    .CNT_W  (TMR_W),
    .RELOAD (GAP_TICKS)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (byte_acc),
    .tick  (tick),
    .count (gap_cnt)
  );

  sat_down_timer #(
    .CNT_W  (TMR_W),
    .RELOAD (DONE_TICKS)
  ) u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_done),
    .tick  (tick),
    .count (done_timer)
  );

  frame_assembler #(
    .DATA_W    (DATA_W),
    .FRAME_LEN (FRAME_LEN),
    .SEED      (SEED)
  ) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_acc   (byte_acc),
    .byte_data  (in_data),
    .err_any    (err_any),
    .gap_zero   (gap_zero),
    .frame_done (frame_done),
    .frame_good (frame_good),
    .frame_bad  (frame_bad),
    .payload    (payload)
  );

  p_done_on_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_good || frame_bad) |-> done_timer == DONE_V);

  p_err_drops_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && err_any) |=> $stable(payload));

endmodule

// File: tb/gap_framed_rx_bench.sv
`timescale 1ns/1ps
module gap_framed_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        err_overrun = 1'b0;
  logic        err_framing = 1'b0;
  logic        err_parity = 1'b0;
  logic        tick = 1'b0;
  logic        frame_good, frame_bad;
  logic [39:0] payload;
  logic [7:0]  done_timer;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int dut_goods = 0;
  int dut_bads = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gap_framed_rx u_gap_framed_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .err_overrun(err_overrun), .err_framing(err_framing),
    .err_parity(err_parity), .tick(tick), .frame_good(frame_good),
    .frame_bad(frame_bad), .payload(payload), .done_timer(done_timer)
  );

  // behavioural reference: a byte queue and two integer timers
  logic [7:0]  q[$];
  int          m_gap = 0;
  int          m_done = 0;
  bit          m_good = 0, m_bad = 0;
  logic [39:0] m_pay = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_gap = 0; m_done = 0; m_good = 0; m_bad = 0; m_pay = '0;
    end else begin
      bit took, fin;
      logic [7:0] x;
      took = 0; fin = 0;
      m_good = 0; m_bad = 0;
      if (err_overrun || err_framing || err_parity) begin
        q.delete();
      end else if (in_valid) begin
        took = 1;
        if (m_gap == 0) q.delete();
        q.push_back(in_data);
        if (q.size() == 6) begin
          x = 8'h5A;
          for (int i = 0; i < 5; i++) x = x ^ q[i];
          if (x == q[5]) begin
            m_good = 1;
            for (int i = 0; i < 5; i++) m_pay[i*8 +: 8] = q[i];
          end else begin
            m_bad = 1;
          end
          q.delete();
          fin = 1;
        end
      end
      if (took) m_gap = 5; else if (tick && m_gap > 0) m_gap = m_gap - 1;
      if (fin) m_done = 20; else if (tick && m_done > 0) m_done = m_done - 1;
    end
  end

  task automatic vec(input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vec("R5 frame_good per cycle", longint'(frame_good), longint'(m_good));
      vec("R5 frame_bad per cycle", longint'(frame_bad), longint'(m_bad));
      vec("R8 payload per cycle", longint'(payload), longint'(m_pay));
      vec("R4 done_timer per cycle", longint'(done_timer), longint'(m_done));
      vec("R9 in_ready per cycle", longint'(in_ready), 64'd1);
      if (frame_good) dut_goods++;
      if (frame_bad) dut_bads++;
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
      summary();
    end
  end

  task automatic cyc(input bit v, input logic [7:0] d, input bit ov,
                     input bit fr, input bit pa, input bit tk);
    @(negedge clk);
    in_valid = v; in_data = d; err_overrun = ov;
    err_framing = fr; err_parity = pa; tick = tk;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0, 1);
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 0, 0, 0);
    #1;
  endtask

  function automatic logic [7:0] cksum(input logic [39:0] p);
    logic [7:0] x;
    x = 8'h5A;
    for (int i = 0; i < 5; i++) x = x ^ p[i*8 +: 8];
    return x;
  endfunction

  task automatic send_frame(input logic [39:0] p, input bit corrupt,
                            input int spacing);
    for (int i = 0; i < 6; i++) begin
      if (i < 5) cyc(1, p[i*8 +: 8], 0, 0, 0, 0);
      else       cyc(1, cksum(p) ^ (corrupt ? 8'h01 : 8'h00), 0, 0, 0, 0);
      if (i < 5 && spacing > 0) ticks(spacing);
    end
  endtask

  localparam logic [39:0] P1 = 40'h44_33_22_11_00;
  localparam logic [39:0] P2 = 40'hA5_5A_FF_01_80;
  localparam logic [39:0] P3 = 40'h0F_1E_2D_3C_4B;
  localparam logic [39:0] P4 = 40'h12_34_56_78_9A;

  initial begin
    for (int i = 0; i < 3; i++) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset values
    vec("R9 reset frame_good", longint'(frame_good), 0);
    vec("R9 reset frame_bad", longint'(frame_bad), 0);
    vec("R9 reset payload", longint'(payload), 0);
    vec("R9 reset done_timer", longint'(done_timer), 0);
    vec("R9 in_ready high", longint'(in_ready), 1);

    // R1 + R5: back-to-back good frame
    send_frame(P1, 0, 0);
    settle();
    vec("R1 R5 good count after first frame", dut_goods, 1);
    vec("R8 payload after first frame", longint'(payload), longint'(P1));

    // R5 + R8: bad check byte keeps payload
    send_frame(P2, 1, 0);
    settle();
    vec("R5 bad count after corrupted frame", dut_bads, 1);
    vec("R8 payload unchanged by bad frame", longint'(payload), longint'(P1));

    // R6: a bad frame followed at once by a good frame
    send_frame(P2, 1, 0);
    send_frame(P2, 0, 0);
    settle();
    vec("R6 good count after wrap", dut_goods, 2);
    vec("R6 bad count after wrap", dut_bads, 2);
    vec("R8 payload second good", longint'(payload), longint'(P2));

    // R2: partial frame, gap expiry after exactly 5 ticks
    cyc(1, 8'hEE, 0, 0, 0, 0); cyc(1, 8'hDD, 0, 0, 0, 0); cyc(1, 8'hCC, 0, 0, 0, 0);
    ticks(5);
    send_frame(P3, 0, 0);
    settle();
    vec("R2 restart after gap expiry", dut_goods, 3);
    vec("R2 no bad frame from stale bytes", dut_bads, 2);

    // R3: 4 ticks between bytes stays inside one frame
    send_frame(P4, 0, 4);
    settle();
    vec("R3 frame spread by 4 ticks holds together", dut_goods, 4);
    vec("R3 payload of spread frame", longint'(payload), longint'(P4));

    // R7: overrun alone drops a partial frame
    cyc(1, 8'h01, 0, 0, 0, 0); cyc(1, 8'h02, 0, 0, 0, 0);
    cyc(0, 8'h00, 1, 0, 0, 0);
    send_frame(P1, 0, 0);
    settle();
    vec("R7 overrun resets position", dut_goods, 5);

    // R7: parity error with a byte in the same cycle, byte dropped
    cyc(1, 8'h01, 0, 0, 0, 0); cyc(1, 8'h02, 0, 0, 0, 0);
    cyc(1, 8'h77, 0, 0, 1, 0);
    send_frame(P3, 0, 0);
    settle();
    vec("R7 parity with byte: byte dropped", dut_goods, 6);
    vec("R7 parity with byte: no bad frame", dut_bads, 2);

    // R7: framing error
    for (int i = 0; i < 4; i++) cyc(1, 8'(i + 9), 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 1, 0, 0);
    send_frame(P2, 0, 0);
    settle();
    vec("R7 framing error resets position", dut_goods, 7);
    vec("R8 payload after framing case", longint'(payload), longint'(P2));

    // R4: completion timer load, countdown, floor
    send_frame(P4, 0, 0);
    settle();
    vec("R4 done_timer loaded", longint'(done_timer), 20);
    ticks(7);
    settle();
    vec("R4 done_timer after 7 ticks", longint'(done_timer), 13);
    ticks(30);
    settle();
    vec("R4 done_timer floor at zero", longint'(done_timer), 0);
    vec("R5 total good pulses", dut_goods, 8);

    summary();
  end

endmodule